// File: doc/BRIEF.md
# Transactional Buffer with Conflict Detection

This block sits beside a core's data port and holds the working set of one hardware memory transaction. The core issues transactional loads, exclusive loads and stores through a request port. Each buffered word carries two versions: the value memory held when the word entered the buffer, and the value the transaction has written. A new value stays inside the buffer and no other agent sees it until the transaction commits. Every request gets a response one cycle later, with a pass/fail flag and, for loads, the word.

Other agents present their reads and writes on a snoop port. A snoop that touches the transaction's working set is a conflict. The block first answers it with a busy signal, which asks the requester to retry. It does this a bounded number of times for the same address, then takes the conflict and marks the transaction failed. Validate reports whether the transaction is still alive. Abort throws away every buffered entry. Commit either fails, if a conflict was taken, or drains the modified entries through a memory write port, one per cycle in entry-index order, and then reports success.

Top module: `txbuf_top`

## Requirements
- R1: After a synchronous active-low reset the buffer is empty, `req_ready` is 1, and `resp_valid`, `mem_wr_valid` and `snp_busy` are 0.
- R2: Every request accepted in cycle t has `resp_valid` high in cycle t+1, except a commit that has entries to drain. A load (op 1) that misses allocates a read-set entry and returns `mem_rd_data`. A load that hits returns the entry's new value, so a stored value is forwarded.
- R3: An exclusive load (op 2) or a store (op 3) puts the word in the write set. A store (op 3) replaces the new value and returns data 0. A snoop read (`snp_we`=0) conflicts only with write-set entries. A snoop read of a read-set-only word does not conflict.
- R4: A snoop write (`snp_we`=1) conflicts with any buffered word, whether it is in the read set or the write set.
- R5: A conflicting snoop raises `snp_busy` in the same cycle. This happens for at most 4 consecutive conflicting snoops to the same address. A snoop that does not conflict, or that targets a different address, restarts the count. The 5th such snoop gets `snp_busy`=0 and fails the transaction. Cycles with `snp_valid` low leave the count unchanged.
- R6: Validate (op 6) returns `resp_ok`=1 while the transaction is alive and 0 once it has failed.
- R7: A commit (op 4) on a live transaction writes back each dirty entry, one per cycle, in ascending entry index. `req_ready` is low while it does so. `resp_valid` and `resp_ok`=1 follow in the cycle after the last write.
- R8: A write-set entry whose new value equals its old value is not written back. A commit with no dirty entries responds in the next cycle with `resp_ok`=1 and no write.
- R9: A commit on a failed transaction returns `resp_ok`=0, writes nothing, clears the buffer and ends the failure.
- R10: Abort (op 5) returns `resp_ok`=1, writes nothing and clears the buffer. A later load of a word that was stored before the abort returns the memory value again.
- R11: A load or store that misses while all 8 entries are valid returns `resp_ok`=0 and fails the transaction. A hit while the buffer is full still succeeds.
- R12: Once the transaction has failed, loads and stores return `resp_ok`=0. A request presented while `req_ready` is low gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | 1 load, 2 exclusive load, 3 store, 4 commit, 5 abort, 6 validate |
| req_addr | input | 16 | Word address of a load or store |
| req_wdata | input | 32 | Store data |
| req_ready | output | 1 | Block accepts requests (low while draining) |
| resp_valid | output | 1 | Response present |
| resp_ok | output | 1 | Pass (1) or fail (0) |
| resp_data | output | 32 | Load data; 0 for other operations |
| mem_rd_addr | output | 16 | Address for the combinational memory read on a miss |
| mem_rd_data | input | 32 | Memory word at `mem_rd_addr` in the same cycle |
| mem_wr_valid | output | 1 | Commit write-back present |
| mem_wr_addr | output | 16 | Write-back address |
| mem_wr_data | output | 32 | Write-back data |
| snp_valid | input | 1 | External access present |
| snp_we | input | 1 | External access is a write |
| snp_addr | input | 16 | External access address |
| snp_busy | output | 1 | Retry request returned to the external agent |

## Verification
The bench checks the busy bound at its edges: four busy answers and a fifth that fails the transaction, and a run broken by a snoop to an unrelated address that must restart the count. An off-by-one counter would fail the transaction one snoop early or one snoop late. A counter that never restarts would fail a transaction that should survive. The commit drain mixes a dirty entry, a clean read entry, a store that wrote back the old value, and a second dirty entry. Wrong ordering, a redundant write-back, or a response in the wrong cycle all show up at the write port. Further tests cover overflow at exactly nine distinct words, snoop reads against read-only words (which must not conflict), and commit and load after a failure; a design that tracked sets or failure wrongly would pass a request that must fail or fail one that must pass.

// File: rtl/txbuf_pkg.sv
// Shared operation codes and control states for the transactional buffer.
package txbuf_pkg;
    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_LOAD     = 3'd1,
        OP_LOADX    = 3'd2,
        OP_STORE    = 3'd3,
        OP_COMMIT   = 3'd4,
        OP_ABORT    = 3'd5,
        OP_VALIDATE = 3'd6
    } txop_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_DRAIN = 1'b1
    } txst_e;
endpackage

// File: rtl/txbuf_pick.sv
// Lowest-index finder: returns whether any bit of vec is set and the index
// of the lowest set bit. Assumes idx is ignored when any is low.
module txbuf_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    // scan from the top so the lowest set bit wins
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/txbuf_store.sv
// Entry array: N fully associative entries, each holding a valid flag,
// read-set and write-set flags, an address tag, an old and a new value.
// One write port, one associative lookup, one indexed read port, and a
// snoop match per entry. Assumes the caller never writes and clears in
// the same cycle.
module txbuf_store #(
    parameter int N  = 8,
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_all,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_tag,
    input  logic          wr_rset,
    input  logic          wr_wset,
    input  logic [DW-1:0] wr_old,
    input  logic [DW-1:0] wr_new,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [IW-1:0] lk_idx,
    output logic          lk_rset,
    output logic [DW-1:0] lk_old,
    output logic [DW-1:0] lk_new,
    output logic [N-1:0]  free_vec,
    output logic [N-1:0]  dirty_vec,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_tag,
    output logic [DW-1:0] rd_new,
    input  logic [AW-1:0] snp_addr,
    input  logic          snp_we,
    output logic [N-1:0]  snp_hit_vec
);
    logic [N-1:0]  hit_vec;
    logic [N-1:0]  rs_vec;
    logic [AW-1:0] tag_a [N];
    logic [DW-1:0] old_a [N];
    logic [DW-1:0] new_a [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic          vld_r;
        logic          rs_r;
        logic          ws_r;
        logic [AW-1:0] tag_r;
        logic [DW-1:0] old_r;
        logic [DW-1:0] new_r;
        logic          sel;

        assign sel = wr_en && (wr_idx == IW'(i));

        // flag bits: cleared by reset or a buffer-wide clear, set on write
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) begin
                vld_r <= 1'b0;
                rs_r  <= 1'b0;
                ws_r  <= 1'b0;
            end else if (sel) begin
                vld_r <= 1'b1;
                rs_r  <= wr_rset;
                ws_r  <= wr_wset;
            end
        end

        // payload: tag and both data versions, qualified by the valid flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_r <= '0;
                old_r <= '0;
                new_r <= '0;
            end else if (sel) begin
                tag_r <= wr_tag;
                old_r <= wr_old;
                new_r <= wr_new;
            end
        end

        assign hit_vec[i]     = vld_r && (tag_r == lk_addr);
        assign free_vec[i]    = !vld_r;
        assign dirty_vec[i]   = vld_r && ws_r && (new_r != old_r);
        assign snp_hit_vec[i] = vld_r && (tag_r == snp_addr) && (ws_r || (snp_we && rs_r));
        assign rs_vec[i]      = rs_r;
        assign tag_a[i]       = tag_r;
        assign old_a[i]       = old_r;
        assign new_a[i]       = new_r;
    end

    txbuf_pick #(.N(N), .IW(IW)) u_lookup (
        .vec (hit_vec),
        .any (lk_hit),
        .idx (lk_idx)
    );

    assign lk_rset = rs_vec[lk_idx];
    assign lk_old  = old_a[lk_idx];
    assign lk_new  = new_a[lk_idx];
    assign rd_tag  = tag_a[rd_idx];
    assign rd_new  = new_a[rd_idx];
endmodule

// File: rtl/txbuf_snoop.sv
// Snoop arbiter: answers a conflicting external access with busy up to
// BUSY_MAX consecutive times for one address, then takes the conflict.
// While draining a commit, conflicts are answered busy without counting.
// Assumes conf is already qualified by snp_valid.
module txbuf_snoop #(
    parameter int AW       = 16,
    parameter int BUSY_MAX = 4,
    parameter int CW       = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          snp_valid,
    input  logic [AW-1:0] snp_addr,
    input  logic          conf,
    input  logic          failed,
    input  logic          draining,
    input  logic          clear,
    output logic          busy,
    output logic          take
);
    logic [CW-1:0] cnt_q, cnt_d;
    logic [AW-1:0] last_q, last_d;
    logic          same;

    assign same = (cnt_q != '0) && (last_q == snp_addr);

    // decide busy or take for the current snoop and update the run count
    always_comb begin
        busy   = 1'b0;
        take   = 1'b0;
        cnt_d  = cnt_q;
        last_d = last_q;
        if (snp_valid) begin
            if (conf && !failed) begin
                if (draining) begin
                    busy  = 1'b1;
                    cnt_d = '0;
                end else if (same && (cnt_q == CW'(BUSY_MAX))) begin
                    take  = 1'b1;
                    cnt_d = '0;
                end else begin
                    busy   = 1'b1;
                    cnt_d  = same ? cnt_q + CW'(1) : CW'(1);
                    last_d = snp_addr;
                end
            end else begin
                cnt_d = '0;
            end
        end
        if (clear) cnt_d = '0;
    end

    // run count and address register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            last_q <= last_d;
        end
    end
endmodule

// File: rtl/txbuf_top.sv
// Transactional buffer top: serves transactional loads, exclusive loads and
// stores from a private entry array, tracks failure from snoop conflicts and
// overflow, and runs commit (ordered drain), abort and validate. Assumes
// mem_rd_data returns the word at mem_rd_addr in the same cycle, and that the
// core holds off requests while req_ready is low.
module txbuf_top #(
    parameter int N_ENTRIES = 8,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int BUSY_MAX  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_ok,
    output logic [DATA_W-1:0] resp_data,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              snp_valid,
    input  logic              snp_we,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_busy
);
    import txbuf_pkg::*;

    localparam int IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
    localparam int CW = $clog2(BUSY_MAX + 1);

    txop_e                op;
    txst_e                st_q, st_d;
    logic                 failed_q, failed_d;
    logic [N_ENTRIES-1:0] drain_q, drain_d;
    logic                 resp_valid_d, resp_ok_d;
    logic [DATA_W-1:0]    resp_data_d;

    logic                 accept, is_mem, eff_fail, overflow;
    logic                 go_drain, drain_last, clr_all;
    logic                 wr_en, wr_rset, wr_wset;
    logic [IW-1:0]        wr_idx;
    logic [DATA_W-1:0]    wr_old, wr_new;
    logic                 lk_hit, lk_rset;
    logic [IW-1:0]        lk_idx;
    logic [DATA_W-1:0]    lk_old, lk_new;
    logic [N_ENTRIES-1:0] free_vec, dirty_vec, snp_hit_vec;
    logic                 free_any, dr_any, snp_take;
    logic [IW-1:0]        free_idx, dr_idx;
    logic [ADDR_W-1:0]    rd_tag;
    logic [DATA_W-1:0]    rd_new;

    assign op          = txop_e'(req_op);
    assign accept      = req_valid && (st_q == ST_RUN);
    assign is_mem      = (op == OP_LOAD) || (op == OP_LOADX) || (op == OP_STORE);
    assign eff_fail    = failed_q || snp_take;
    assign mem_rd_addr = req_addr;
    assign req_ready   = (st_q == ST_RUN);

    txbuf_store #(.N(N_ENTRIES), .AW(ADDR_W), .DW(DATA_W), .IW(IW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_all     (clr_all),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_tag      (req_addr),
        .wr_rset     (wr_rset),
        .wr_wset     (wr_wset),
        .wr_old      (wr_old),
        .wr_new      (wr_new),
        .lk_addr     (req_addr),
        .lk_hit      (lk_hit),
        .lk_idx      (lk_idx),
        .lk_rset     (lk_rset),
        .lk_old      (lk_old),
        .lk_new      (lk_new),
        .free_vec    (free_vec),
        .dirty_vec   (dirty_vec),
        .rd_idx      (dr_idx),
        .rd_tag      (rd_tag),
        .rd_new      (rd_new),
        .snp_addr    (snp_addr),
        .snp_we      (snp_we),
        .snp_hit_vec (snp_hit_vec)
    );

    txbuf_pick #(.N(N_ENTRIES), .IW(IW)) u_free (
        .vec (free_vec),
        .any (free_any),
        .idx (free_idx)
    );

    txbuf_pick #(.N(N_ENTRIES), .IW(IW)) u_drain (
        .vec (drain_q),
        .any (dr_any),
        .idx (dr_idx)
    );

    txbuf_snoop #(.AW(ADDR_W), .BUSY_MAX(BUSY_MAX), .CW(CW)) u_snoop (
        .clk       (clk),
        .rst_n     (rst_n),
        .snp_valid (snp_valid),
        .snp_addr  (snp_addr),
        .conf      (snp_valid && (|snp_hit_vec)),
        .failed    (failed_q),
        .draining  (st_q == ST_DRAIN),
        .clear     (clr_all),
        .busy      (snp_busy),
        .take      (snp_take)
    );

    // entry write for loads and stores: update on hit, allocate on miss
    always_comb begin
        wr_en    = 1'b0;
        wr_idx   = lk_idx;
        wr_rset  = lk_rset;
        wr_wset  = 1'b1;
        wr_old   = lk_old;
        wr_new   = (op == OP_STORE) ? req_wdata : lk_new;
        overflow = 1'b0;
        if (accept && is_mem && !eff_fail) begin
            if (lk_hit) begin
                wr_en = (op != OP_LOAD);
            end else if (free_any) begin
                wr_en   = 1'b1;
                wr_idx  = free_idx;
                wr_rset = (op == OP_LOAD);
                wr_wset = (op != OP_LOAD);
                wr_old  = mem_rd_data;
                wr_new  = (op == OP_STORE) ? req_wdata : mem_rd_data;
            end else begin
                overflow = 1'b1;
            end
        end
    end

    // commit, abort and drain control
    always_comb begin
        go_drain   = accept && (op == OP_COMMIT) && !eff_fail && (|dirty_vec);
        drain_last = (st_q == ST_DRAIN) && $onehot(drain_q);
        clr_all    = (accept && ((op == OP_ABORT) || ((op == OP_COMMIT) && !go_drain)))
                     || drain_last;
        st_d       = st_q;
        drain_d    = drain_q;
        if (go_drain) begin
            st_d    = ST_DRAIN;
            drain_d = dirty_vec;
        end else if (st_q == ST_DRAIN) begin
            drain_d = drain_q & ~(N_ENTRIES'(1) << dr_idx);
            if (drain_last) st_d = ST_RUN;
        end
        failed_d = clr_all ? 1'b0 : (failed_q || snp_take || overflow);
    end

    // response formation for the request accepted this cycle
    always_comb begin
        resp_valid_d = 1'b0;
        resp_ok_d    = 1'b0;
        resp_data_d  = '0;
        if (drain_last) begin
            resp_valid_d = 1'b1;
            resp_ok_d    = 1'b1;
        end else if (accept && !go_drain) begin
            unique case (op)
                OP_LOAD, OP_LOADX: begin
                    resp_valid_d = 1'b1;
                    resp_ok_d    = !eff_fail && !overflow;
                    if (resp_ok_d) resp_data_d = lk_hit ? lk_new : mem_rd_data;
                end
                OP_STORE: begin
                    resp_valid_d = 1'b1;
                    resp_ok_d    = !eff_fail && !overflow;
                end
                OP_COMMIT, OP_VALIDATE: begin
                    resp_valid_d = 1'b1;
                    resp_ok_d    = !eff_fail;
                end
                OP_ABORT: begin
                    resp_valid_d = 1'b1;
                    resp_ok_d    = 1'b1;
                end
                default: resp_valid_d = 1'b0;
            endcase
        end
    end

    // control state, failure flag, drain mask and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_RUN;
            failed_q   <= 1'b0;
            drain_q    <= '0;
            resp_valid <= 1'b0;
            resp_ok    <= 1'b0;
            resp_data  <= '0;
        end else begin
            st_q       <= st_d;
            failed_q   <= failed_d;
            drain_q    <= drain_d;
            resp_valid <= resp_valid_d;
            resp_ok    <= resp_ok_d;
            resp_data  <= resp_data_d;
        end
    end

    assign mem_wr_valid = (st_q == ST_DRAIN) && dr_any;
    assign mem_wr_addr  = rd_tag;
    assign mem_wr_data  = rd_new;
endmodule

// File: rtl/txbuf_checker.sv
// Port-level temporal checks for the transactional buffer, bound to the top.
// The busy-run checker keeps its own count of consecutive busy answers.
module txbuf_checker #(
    parameter int AW       = 16,
    parameter int BUSY_MAX = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          resp_valid,
    input logic          resp_ok,
    input logic          mem_wr_valid,
    input logic          snp_valid,
    input logic [AW-1:0] snp_addr,
    input logic          snp_busy
);
    localparam int KW = $clog2(BUSY_MAX + 2) + 1;

    logic [KW-1:0] run_q;
    logic [AW-1:0] last_q;
    logic          same;

    assign same = (run_q != '0) && (snp_addr == last_q);

    // count consecutive busy answers to one address outside of a drain
    always_ff @(posedge clk) begin
        if (!rst_n || resp_valid) begin
            run_q  <= '0;
            last_q <= '0;
        end else if (snp_valid) begin
            if (snp_busy && req_ready) begin
                run_q  <= same ? run_q + KW'(1) : KW'(1);
                last_q <= snp_addr;
            end else begin
                run_q <= '0;
            end
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_ready && !resp_valid && !mem_wr_valid));

    assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_busy && req_ready && same) |-> (run_q < KW'(BUSY_MAX)));

    assert_busy_needs_snoop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        snp_busy |-> snp_valid);

    assert_wb_only_draining_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> (!req_ready && !resp_valid));

    assert_done_after_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_valid) |-> (resp_valid && resp_ok));

    assert_drain_ends_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !mem_wr_valid) |=> req_ready);
endmodule

bind txbuf_top txbuf_checker #(.AW(ADDR_W), .BUSY_MAX(BUSY_MAX)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .resp_valid   (resp_valid),
    .resp_ok      (resp_ok),
    .mem_wr_valid (mem_wr_valid),
    .snp_valid    (snp_valid),
    .snp_addr     (snp_addr),
    .snp_busy     (snp_busy)
);

// File: tb/txbuf_top_bench.sv
module txbuf_top_bench;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic        ok;
        logic [31:0] data;
    } vec_t;

    // walked in order from an empty buffer
    localparam vec_t VT [9] = '{
        '{3'd1, 16'h0010, 32'h0,         1'b1, 32'hC0DE0010},
        '{3'd1, 16'h0010, 32'h0,         1'b1, 32'hC0DE0010},
        '{3'd3, 16'h0010, 32'h11111111,  1'b1, 32'h0},
        '{3'd1, 16'h0010, 32'h0,         1'b1, 32'h11111111},
        '{3'd2, 16'h0020, 32'h0,         1'b1, 32'hC0DE0020},
        '{3'd6, 16'h0000, 32'h0,         1'b1, 32'h0},
        '{3'd5, 16'h0000, 32'h0,         1'b1, 32'h0},
        '{3'd1, 16'h0010, 32'h0,         1'b1, 32'hC0DE0010},
        '{3'd5, 16'h0000, 32'h0,         1'b1, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic [31:0] req_wdata = 32'h0;
    logic        req_ready, resp_valid, resp_ok;
    logic [31:0] resp_data;
    logic [15:0] mem_rd_addr;
    logic [31:0] mem_rd_data;
    logic        mem_wr_valid;
    logic [15:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        snp_valid = 1'b0;
    logic        snp_we = 1'b0;
    logic [15:0] snp_addr = 16'h0;
    logic        snp_busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P / 2) clk = ~clk;
    assign mem_rd_data = {16'hC0DE, mem_rd_addr};

    txbuf_top u_txbuf_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_ok(resp_ok), .resp_data(resp_data),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .snp_valid(snp_valid), .snp_we(snp_we),
        .snp_addr(snp_addr), .snp_busy(snp_busy)
    );

    task automatic chk(input bit pass, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!pass) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one request, response sampled in the following cycle
    task automatic do_op(input logic [2:0] op, input logic [15:0] a, input logic [31:0] d,
                         output logic v, output logic ok, output logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd0;
        v = resp_valid; ok = resp_ok; data = resp_data;
    endtask

    // one snoop cycle; busy sampled before the next rising edge
    task automatic snoop(input logic we, input logic [15:0] a, output logic busy);
        @(negedge clk);
        snp_valid = 1'b1; snp_we = we; snp_addr = a;
        #(CLK_P / 4);
        busy = snp_busy;
        @(posedge clk);
        #1 snp_valid = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic v, ok, b;
        logic [31:0] d;
        logic [15:0] wa [8];
        logic [31:0] wd [8];
        int nw;
        bit got;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready && !resp_valid && !mem_wr_valid && !snp_busy, "R1 reset outputs",
            {28'h0, req_ready, resp_valid, mem_wr_valid, snp_busy}, 32'h8);
        rst_n = 1'b1;

        // R2 R3 R6 R10: vector table
        for (int i = 0; i < 9; i++) begin
            do_op(VT[i].op, VT[i].addr, VT[i].wdata, v, ok, d);
            chk(v && ok == VT[i].ok && d == VT[i].data, $sformatf("R2 vector %0d", i),
                d, VT[i].data);
        end

        // R7 R8 R12: ordered drain with clean and redundant write-set entries
        do_op(3'd3, 16'h0030, 32'hAAAA0001, v, ok, d);
        do_op(3'd1, 16'h0031, 32'h0, v, ok, d);
        do_op(3'd3, 16'h0032, 32'hC0DE0032, v, ok, d);
        do_op(3'd3, 16'h0033, 32'hBBBB0003, v, ok, d);
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd4;
        nw = 0; got = 1'b0;
        for (int c = 0; c < 20 && !got; c++) begin
            @(negedge clk);
            if (c == 0) begin
                chk(!req_ready, "R7 not ready while draining", {31'h0, req_ready}, 32'h0);
                req_op = 3'd1; req_addr = 16'h0040;
            end else begin
                req_valid = 1'b0; req_op = 3'd0;
            end
            if (mem_wr_valid && nw < 8) begin
                wa[nw] = mem_wr_addr; wd[nw] = mem_wr_data; nw++;
            end
            if (resp_valid) begin
                got = 1'b1;
                chk(ok_ok(resp_ok), "R7 commit ok", {31'h0, resp_ok}, 32'h1);
            end
        end
        req_valid = 1'b0; req_op = 3'd0;
        chk(nw == 2, "R8 write-back count", nw, 2);
        chk(nw == 2 && wa[0] == 16'h0030 && wd[0] == 32'hAAAA0001, "R7 first write-back",
            {wa[0], wd[0][15:0]}, {16'h0030, 16'h0001});
        chk(nw == 2 && wa[1] == 16'h0033 && wd[1] == 32'hBBBB0003, "R7 second write-back",
            {wa[1], wd[1][15:0]}, {16'h0033, 16'h0003});
        @(negedge clk);
        chk(!resp_valid, "R12 request during drain ignored", {31'h0, resp_valid}, 32'h0);
        do_op(3'd1, 16'h0030, 32'h0, v, ok, d);
        chk(v && ok && d == 32'hC0DE0030, "R7 buffer cleared after commit", d, 32'hC0DE0030);

        // R8: commit with nothing dirty
        do_op(3'd4, 16'h0, 32'h0, v, ok, d);
        chk(v && ok && !mem_wr_valid, "R8 clean commit", {30'h0, v, ok}, 32'h3);

        // R3 R4 R5 R6 R9 R12: snoop on a read-set word
        do_op(3'd1, 16'h0060, 32'h0, v, ok, d);
        snoop(1'b0, 16'h0060, b);
        chk(!b, "R3 read snoop of read set", {31'h0, b}, 32'h0);
        do_op(3'd6, 16'h0, 32'h0, v, ok, d);
        chk(v && ok, "R6 alive after harmless snoop", {31'h0, ok}, 32'h1);
        for (int k = 0; k < 4; k++) begin
            snoop(1'b1, 16'h0060, b);
            chk(b, $sformatf("R4 busy on write snoop %0d", k), {31'h0, b}, 32'h1);
        end
        snoop(1'b1, 16'h0060, b);
        chk(!b, "R5 fifth snoop taken", {31'h0, b}, 32'h0);
        do_op(3'd6, 16'h0, 32'h0, v, ok, d);
        chk(v && !ok, "R6 failed after conflict", {31'h0, ok}, 32'h0);
        do_op(3'd1, 16'h0070, 32'h0, v, ok, d);
        chk(v && !ok, "R12 load after failure", {31'h0, ok}, 32'h0);
        do_op(3'd4, 16'h0, 32'h0, v, ok, d);
        chk(v && !ok && !mem_wr_valid, "R9 failed commit", {31'h0, ok}, 32'h0);
        do_op(3'd6, 16'h0, 32'h0, v, ok, d);
        chk(v && ok, "R9 failure cleared by commit", {31'h0, ok}, 32'h1);

        // R3 R5: write-set word, run broken by an unrelated snoop
        do_op(3'd2, 16'h0080, 32'h0, v, ok, d);
        for (int k = 0; k < 3; k++) snoop(1'b0, 16'h0080, b);
        chk(b, "R3 read snoop of write set busy", {31'h0, b}, 32'h1);
        snoop(1'b1, 16'h0099, b);
        chk(!b, "R5 unrelated snoop not busy", {31'h0, b}, 32'h0);
        for (int k = 0; k < 4; k++) begin
            snoop(1'b0, 16'h0080, b);
            chk(b, $sformatf("R5 count restarted %0d", k), {31'h0, b}, 32'h1);
        end
        do_op(3'd6, 16'h0, 32'h0, v, ok, d);
        chk(v && ok, "R5 still alive", {31'h0, ok}, 32'h1);
        do_op(3'd5, 16'h0, 32'h0, v, ok, d);
        chk(v && ok && !mem_wr_valid, "R10 abort", {31'h0, ok}, 32'h1);

        // R11: capacity
        for (int k = 0; k < 8; k++) do_op(3'd1, 16'h0100 + 16'(k), 32'h0, v, ok, d);
        chk(v && ok, "R11 eighth entry", {31'h0, ok}, 32'h1);
        do_op(3'd1, 16'h0103, 32'h0, v, ok, d);
        chk(v && ok && d == 32'hC0DE0103, "R11 hit while full", d, 32'hC0DE0103);
        do_op(3'd3, 16'h0108, 32'h5, v, ok, d);
        chk(v && !ok, "R11 overflow fails", {31'h0, ok}, 32'h0);
        do_op(3'd6, 16'h0, 32'h0, v, ok, d);
        chk(v && !ok, "R11 validate after overflow", {31'h0, ok}, 32'h0);
        do_op(3'd5, 16'h0, 32'h0, v, ok, d);
        do_op(3'd6, 16'h0, 32'h0, v, ok, d);
        chk(v && ok, "R10 abort clears failure", {31'h0, ok}, 32'h1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic bit ok_ok(input logic r);
        return r === 1'b1;
    endfunction
endmodule